// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block assembles flow-control frames that ask the link partner to stop sending (XOFF) or to resume (XON). It presents them to the transmit path as a byte stream, one byte per clock, with valid, start-of-frame and end-of-frame markers. Each frame is 60 bytes long. It carries a fixed multicast destination, the configured station address as source, the MAC-control type and pause opcode, and a 2-byte quanta field. The frame ends with zero padding. The frame check sequence and preamble are added further down the transmit path.

Requests come from three places: one-cycle command strobes from the configuration space, dedicated request pins, and a receive-buffer fill-level signal. When the fill-level signal rises, the block asks for XOFF. When it falls, the block asks for XON. A request is held pending until the transmit path reports idle. A holdoff timer, counted in 512-bit-time units of 64 cycles each, sets a minimum spacing between successive XOFF frames. XON frames never wait for the holdoff timer. A master enable turns the whole function off.

Top module: `fc_pause_gen`

## Requirements
- R1: A frame is exactly 60 consecutive valid bytes. `out_sof` is high only on byte 0 and `out_eof` is high only on byte 59. While no frame is being sent, `out_valid`, `out_sof`, `out_eof` and `out_data` are all zero.
- R2: Bytes 0 to 5 are the destination 01 80 C2 00 00 01, sent in that order.
- R3: Bytes 6 to 11 are the station address {`sa_upper`,`sa_lower`}, most significant byte first. Bytes 12 and 13 are 0x88 0x08 (type). Bytes 14 and 15 are 0x00 0x01 (opcode).
- R4: In an XOFF frame, bytes 16 and 17 carry `pause_quanta`, high byte first. Addresses and quanta are sampled on the launch edge, so a change during a frame does not affect that frame.
- R5: In an XON frame, bytes 16 and 17 are 0x00 0x00.
- R6: Bytes 18 to 59 are 42 pad bytes of 0x00.
- R7: An XOFF request is raised by a `cfg_xoff_cmd` strobe, by `pin_xoff_req`, or by a 0 to 1 change of `rx_fill_high`. An XON request is raised by `cfg_xon_cmd`, by `pin_xon_req`, or by a 1 to 0 change of `rx_fill_high`.
- R8: A frame launches only on a clock edge where `tx_idle` is high and no frame is in progress. Byte 0 appears in the cycle after that edge. Once started, a frame is never interrupted.
- R9: An XOFF frame launches no sooner than `holdoff_quanta`×64+1 cycles after the previous XOFF launch. A pending XON frame is not delayed by the holdoff timer.
- R10: One request is held pending. XOFF and XON requests raised in the same cycle leave only XOFF pending. A later request replaces a pending request of the other kind.
- R11: While `fc_enable` is low, requests are ignored, any pending request is discarded, and no frame launches. A frame already in progress still completes.
- R12: After reset, nothing is pending, the holdoff timer is clear and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_enable | input | 1 | Master enable for pause generation |
| cfg_xoff_cmd | input | 1 | Configuration strobe requesting XOFF |
| cfg_xon_cmd | input | 1 | Configuration strobe requesting XON |
| pin_xoff_req | input | 1 | Request pin for XOFF |
| pin_xon_req | input | 1 | Request pin for XON |
| rx_fill_high | input | 1 | Receive-buffer above-threshold level |
| sa_upper | input | 16 | Station address bits 47:32 |
| sa_lower | input | 32 | Station address bits 31:0 |
| pause_quanta | input | 16 | Quanta value sent in XOFF frames |
| holdoff_quanta | input | 16 | Minimum XOFF spacing in 64-cycle units |
| tx_idle | input | 1 | Transmit path is idle and may accept a frame |
| out_valid | output | 1 | Byte on `out_data` is valid |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_data | output | 8 | Frame byte |

## Verification
The assertions assume that `tx_idle` truly reflects the transmit path and that the transmit path consumes one byte on every valid cycle, with no way to stall the stream. The bench drives all inputs on the falling edge and holds them for whole cycles, and it never needs backpressure. The launch checks also assume that `fc_enable` is sampled on the same edge as the requests. The stimulus therefore changes the enable only between edges, including once in the middle of a frame.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

    localparam int unsigned FRAME_LEN  = 60;
    localparam int unsigned IDX_W      = $clog2(FRAME_LEN);
    localparam int unsigned QUANTA_W   = 16;
    localparam int unsigned ADDR_W     = 48;

    localparam logic [47:0] PF_DEST   = 48'h0180_C200_0001;
    localparam logic [15:0] PF_TYPE   = 16'h8808;
    localparam logic [15:0] PF_OPCODE = 16'h0001;

    typedef enum logic {
        PF_XON  = 1'b0,
        PF_XOFF = 1'b1
    } pf_kind_e;

    typedef struct packed {
        pf_kind_e              kind;
        logic [ADDR_W-1:0]     sa;
        logic [QUANTA_W-1:0]   quanta;
    } pf_snap_t;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } pf_beat_t;

    function automatic logic [7:0] pf_byte(input pf_snap_t s, input int unsigned i);
        logic [47:0] w48;
        logic [15:0] w16;
        logic [15:0] q;
        q = (s.kind == PF_XOFF) ? s.quanta : 16'h0000;
        w48 = '0;
        w16 = '0;
        if (i < 6) begin
            w48 = PF_DEST >> (8 * (5 - i));
            return w48[7:0];
        end else if (i < 12) begin
            w48 = s.sa >> (8 * (11 - i));
            return w48[7:0];
        end else if (i < 14) begin
            w16 = PF_TYPE >> (8 * (13 - i));
            return w16[7:0];
        end else if (i < 16) begin
            w16 = PF_OPCODE >> (8 * (15 - i));
            return w16[7:0];
        end else if (i < 18) begin
            w16 = q >> (8 * (17 - i));
            return w16[7:0];
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/fcp_holdoff.sv
module fcp_holdoff
    import fcp_pkg::*;
#(
    parameter int unsigned CYC_PER_QUANTUM = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [QUANTA_W-1:0] quanta,
    output logic                expired
);
    localparam int unsigned CW = QUANTA_W + $clog2(CYC_PER_QUANTUM) + 1;

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(quanta) * CW'(CYC_PER_QUANTUM);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/fcp_req_ctrl.sv
module fcp_req_ctrl
    import fcp_pkg::*;
#(
    parameter int unsigned CYC_PER_QUANTUM = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                xoff_cmd,
    input  logic                xon_cmd,
    input  logic                xoff_pin,
    input  logic                xon_pin,
    input  logic                fill_high,
    input  logic [QUANTA_W-1:0] holdoff_quanta,
    input  logic                tx_idle,
    input  logic                frame_busy,
    output logic                launch,
    output pf_kind_e            launch_kind
);
    logic     fill_q;
    logic     want_xoff;
    logic     want_xon;
    logic     pend_v;
    pf_kind_e pend_k;
    logic     gap_clear;
    logic     kind_ok;

    always_ff @(posedge clk) begin
        if (rst) fill_q <= 1'b0;
        else     fill_q <= fill_high;
    end

    assign want_xoff = xoff_cmd | xoff_pin | (fill_high & ~fill_q);
    assign want_xon  = xon_cmd  | xon_pin  | (~fill_high & fill_q);

    assign kind_ok     = (pend_k == PF_XON) | gap_clear;
    assign launch      = enable & pend_v & tx_idle & ~frame_busy & kind_ok;
    assign launch_kind = pend_k;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_k <= PF_XON;
        end else if (!enable) begin
            pend_v <= 1'b0;
        end else if (want_xoff) begin
            pend_v <= 1'b1;
            pend_k <= PF_XOFF;
        end else if (want_xon) begin
            pend_v <= 1'b1;
            pend_k <= PF_XON;
        end else if (launch) begin
            pend_v <= 1'b0;
        end
    end

    fcp_holdoff #(
        .CYC_PER_QUANTUM(CYC_PER_QUANTUM)
    ) u_holdoff (
        .clk     (clk),
        .rst     (rst),
        .load    (launch && (pend_k == PF_XOFF)),
        .quanta  (holdoff_quanta),
        .expired (gap_clear)
    );

endmodule

// File: rtl/fcp_frame_seq.sv
module fcp_frame_seq
    import fcp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  pf_kind_e            launch_kind,
    input  logic [ADDR_W-1:0]   sa,
    input  logic [QUANTA_W-1:0] quanta,
    output logic                active,
    output pf_beat_t            beat
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [IDX_W-1:0] idx;
    pf_snap_t         snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            snap   <= '0;
        end else if (launch) begin
            active      <= 1'b1;
            idx         <= '0;
            snap.kind   <= launch_kind;
            snap.sa     <= sa;
            snap.quanta <= quanta;
        end else if (active) begin
            if (idx == LAST_IDX) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        beat       = '0;
        beat.valid = active;
        beat.sof   = active && (idx == '0);
        beat.eof   = active && (idx == LAST_IDX);
        beat.data  = active ? pf_byte(snap, 32'(idx)) : 8'h00;
    end

endmodule

// File: rtl/fc_pause_gen.sv
module fc_pause_gen
    import fcp_pkg::*;
#(
    parameter int unsigned CYC_PER_QUANTUM = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fc_enable,
    input  logic        cfg_xoff_cmd,
    input  logic        cfg_xon_cmd,
    input  logic        pin_xoff_req,
    input  logic        pin_xon_req,
    input  logic        rx_fill_high,
    input  logic [15:0] sa_upper,
    input  logic [31:0] sa_lower,
    input  logic [15:0] pause_quanta,
    input  logic [15:0] holdoff_quanta,
    input  logic        tx_idle,
    output logic        out_valid,
    output logic        out_sof,
    output logic        out_eof,
    output logic [7:0]  out_data
);
    logic     launch;
    pf_kind_e launch_kind;
    logic     busy;
    pf_beat_t beat;

    fcp_req_ctrl #(
        .CYC_PER_QUANTUM(CYC_PER_QUANTUM)
    ) u_req (
        .clk            (clk),
        .rst            (rst),
        .enable         (fc_enable),
        .xoff_cmd       (cfg_xoff_cmd),
        .xon_cmd        (cfg_xon_cmd),
        .xoff_pin       (pin_xoff_req),
        .xon_pin        (pin_xon_req),
        .fill_high      (rx_fill_high),
        .holdoff_quanta (holdoff_quanta),
        .tx_idle        (tx_idle),
        .frame_busy     (busy),
        .launch         (launch),
        .launch_kind    (launch_kind)
    );

    fcp_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_kind (launch_kind),
        .sa          ({sa_upper, sa_lower}),
        .quanta      (pause_quanta),
        .active      (busy),
        .beat        (beat)
    );

    assign out_valid = beat.valid;
    assign out_sof   = beat.sof;
    assign out_eof   = beat.eof;
    assign out_data  = beat.data;

endmodule

// File: rtl/fcp_checker.sv
module fcp_checker
    import fcp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       fc_enable,
    input logic       tx_idle,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic [7:0] out_data
);
    logic [7:0] beats_seen;

    always_ff @(posedge clk) begin
        if (rst)            beats_seen <= '0;
        else if (out_sof)   beats_seen <= 8'd1;
        else if (out_valid) beats_seen <= beats_seen + 8'd1;
    end

    // R1: last marker only after a full-length run of beats
    a_r1_frame_length: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (beats_seen == 8'(FRAME_LEN - 1)));

    a_r1_markers_valid: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eof) |-> (out_valid && !(out_sof && out_eof)));

    a_r2_dest_head: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_data == 8'h01));

    a_r8_unbroken: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |=> out_valid);

    a_r8_launch_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(tx_idle));

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!fc_enable && !out_valid) |=> !out_valid);

endmodule

bind fc_pause_gen fcp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .fc_enable (fc_enable),
    .tx_idle   (tx_idle),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_data  (out_data)
);

// File: tb/sim_fc_pause_gen.sv
`timescale 1ns/1ps
module sim_fc_pause_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        fc_enable, cfg_xoff_cmd, cfg_xon_cmd, pin_xoff_req, pin_xon_req;
    logic        rx_fill_high, tx_idle;
    logic [15:0] sa_upper, pause_quanta, holdoff_quanta;
    logic [31:0] sa_lower;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    fc_pause_gen u0 (
        .clk(clk), .rst(rst), .fc_enable(fc_enable),
        .cfg_xoff_cmd(cfg_xoff_cmd), .cfg_xon_cmd(cfg_xon_cmd),
        .pin_xoff_req(pin_xoff_req), .pin_xon_req(pin_xon_req),
        .rx_fill_high(rx_fill_high), .sa_upper(sa_upper), .sa_lower(sa_lower),
        .pause_quanta(pause_quanta), .holdoff_quanta(holdoff_quanta),
        .tx_idle(tx_idle), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_data(out_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] exp_q[$];
    bit  m_pend, m_pend_off, m_fill, m_frame_off;
    int  m_hold;

    function automatic void push_frame(input bit is_off);
        logic [47:0] sa;
        logic [15:0] q;
        sa = {sa_upper, sa_lower};
        q  = is_off ? pause_quanta : 16'h0000;
        exp_q.push_back(8'h01); exp_q.push_back(8'h80); exp_q.push_back(8'hC2);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h01);
        for (int k = 5; k >= 0; k--) exp_q.push_back(sa[8*k +: 8]);
        exp_q.push_back(8'h88); exp_q.push_back(8'h08);
        exp_q.push_back(8'h00); exp_q.push_back(8'h01);
        exp_q.push_back(q[15:8]); exp_q.push_back(q[7:0]);
        for (int k = 0; k < 42; k++) exp_q.push_back(8'h00);
        m_frame_off = is_off;
    endfunction

    always @(posedge clk) begin
        bit busy, off_ev, on_ev, go;
        logic [7:0] drop;
        cyc++;
        if (rst) begin
            exp_q.delete();
            m_pend = 0; m_pend_off = 0; m_hold = 0; m_fill = 0;
        end else begin
            busy = (exp_q.size() > 0);
            if (busy) drop = exp_q.pop_front();
            off_ev = cfg_xoff_cmd || pin_xoff_req || (rx_fill_high && !m_fill);
            on_ev  = cfg_xon_cmd  || pin_xon_req  || (!rx_fill_high && m_fill);
            go = fc_enable && m_pend && tx_idle && !busy && (!m_pend_off || m_hold == 0);
            if (go) push_frame(m_pend_off);
            if (go && m_pend_off) m_hold = holdoff_quanta * 64;
            else if (m_hold > 0) m_hold--;
            if (!fc_enable) m_pend = 0;
            else if (off_ev) begin m_pend = 1; m_pend_off = 1; end
            else if (on_ev) begin m_pend = 1; m_pend_off = 0; end
            else if (go) m_pend = 0;
            m_fill = rx_fill_high;
        end
    end

    // ---------------- monitor / per-cycle compare ----------------
    int n_sof = 0, n_eof = 0, pos = 0, sof_last = 0, sof_prev = 0;
    logic [15:0] last_q = 16'h0;

    always @(negedge clk) begin
        if (!rst) begin
            int p;
            string tg;
            if (exp_q.size() == 0) begin
                chk("R8 idle valid", out_valid, 0);
                chk("R1 idle data", out_data, 0);
            end else begin
                p = 60 - exp_q.size();
                if (p < 6)       tg = "R2 dest";
                else if (p < 16) tg = "R3 sa/type/opcode";
                else if (p < 18) tg = m_frame_off ? "R4 xoff quanta" : "R5 xon quanta";
                else             tg = "R6 pad";
                chk("R8 valid", out_valid, 1);
                chk(tg, out_data, exp_q[0]);
                chk("R1 sof", out_sof, (p == 0));
                chk("R1 eof", out_eof, (p == 59));
            end
            if (out_valid) begin
                if (out_sof) begin
                    pos = 0; n_sof++; sof_prev = sof_last; sof_last = cyc;
                end else pos++;
                if (pos == 16) last_q[15:8] = out_data;
                if (pos == 17) last_q[7:0]  = out_data;
                if (out_eof) n_eof++;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int base;
        rst = 1; fc_enable = 1; cfg_xoff_cmd = 0; cfg_xon_cmd = 0;
        pin_xoff_req = 0; pin_xon_req = 0; rx_fill_high = 0; tx_idle = 1;
        sa_upper = 16'hA1B2; sa_lower = 32'hC3D4E5F6;
        pause_quanta = 16'h1234; holdoff_quanta = 16'h0;
        repeat (4) @(negedge clk);
        chk("R12 reset valid", out_valid, 0);
        chk("R12 reset sof/eof", {out_sof, out_eof}, 0);
        chk("R12 reset data", out_data, 0);
        rst = 0;
        idle_for(20);
        chk("R12 nothing pending", n_sof, 0);

        // XOFF by configuration strobe
        base = n_sof;
        cfg_xoff_cmd = 1; @(negedge clk); cfg_xoff_cmd = 0;
        idle_for(70);
        chk("R7 cfg xoff launches", n_sof, base + 1);
        chk("R4 quanta field", last_q, 16'h1234);

        // XON by pin
        base = n_sof;
        pin_xon_req = 1; @(negedge clk); pin_xon_req = 0;
        idle_for(70);
        chk("R7 pin xon launches", n_sof, base + 1);
        chk("R5 xon quanta zero", last_q, 16'h0000);

        // wait for idle
        base = n_sof;
        tx_idle = 0;
        pin_xoff_req = 1; @(negedge clk); pin_xoff_req = 0;
        idle_for(30);
        chk("R8 held while busy", n_sof, base);
        tx_idle = 1;
        idle_for(70);
        chk("R8 launches on idle", n_sof, base + 1);

        // holdoff spacing between two XOFF launches
        holdoff_quanta = 16'd2;
        base = n_sof;
        cfg_xoff_cmd = 1; @(negedge clk); cfg_xoff_cmd = 0;
        idle_for(10);
        pin_xoff_req = 1; @(negedge clk); pin_xoff_req = 0;
        idle_for(200);
        chk("R9 two xoff frames", n_sof, base + 2);
        chk("R9 holdoff gap", sof_last - sof_prev, 2 * 64 + 1);

        // XON bypasses holdoff; it replaces pending XOFF
        base = n_sof;
        cfg_xoff_cmd = 1; @(negedge clk); cfg_xoff_cmd = 0;
        idle_for(3);
        chk("R9 xoff held by holdoff", n_sof, base);
        cfg_xon_cmd = 1; @(negedge clk); cfg_xon_cmd = 0;
        idle_for(5);
        chk("R9 xon not held", n_sof, base + 1);
        idle_for(70);
        chk("R10 xon replaced xoff", last_q, 16'h0000);
        idle_for(200);
        chk("R10 replaced xoff dropped", n_sof, base + 1);
        holdoff_quanta = 16'd0;

        // same-cycle XON and XOFF
        base = n_sof;
        pause_quanta = 16'h00FF;
        cfg_xon_cmd = 1; pin_xoff_req = 1; @(negedge clk);
        cfg_xon_cmd = 0; pin_xoff_req = 0;
        idle_for(70);
        chk("R10 one frame", n_sof, base + 1);
        chk("R10 xoff wins", last_q, 16'h00FF);

        // fill-level edges
        base = n_sof;
        rx_fill_high = 1;
        idle_for(70);
        chk("R7 fill rise -> frame", n_sof, base + 1);
        chk("R7 fill rise -> xoff", last_q, 16'h00FF);
        rx_fill_high = 0;
        idle_for(70);
        chk("R7 fill fall -> frame", n_sof, base + 2);
        chk("R7 fill fall -> xon", last_q, 16'h0000);

        // quanta captured at launch
        sa_upper = 16'h0102; sa_lower = 32'h03040506;
        pause_quanta = 16'hBEEF;
        cfg_xoff_cmd = 1; @(negedge clk); cfg_xoff_cmd = 0;
        idle_for(8);
        pause_quanta = 16'h0F0F;
        idle_for(70);
        chk("R4 quanta sampled at launch", last_q, 16'hBEEF);

        // disable
        base = n_sof;
        fc_enable = 0;
        cfg_xoff_cmd = 1; @(negedge clk); cfg_xoff_cmd = 0;
        idle_for(20);
        chk("R11 no frame when disabled", n_sof, base);
        fc_enable = 1;
        idle_for(80);
        chk("R11 request discarded", n_sof, base);

        // disable mid-frame: frame completes
        base = n_eof;
        pin_xon_req = 1; @(negedge clk); pin_xon_req = 0;
        idle_for(5);
        fc_enable = 0;
        idle_for(70);
        chk("R11 frame in flight completes", n_eof, base + 1);
        fc_enable = 1;
        idle_for(5);

        chk("R1 every start has an end", n_eof, n_sof);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule